// File: doc/BRIEF.md
# SRAM Wait-State Access Controller

This controller connects a simple internal request bus to an asynchronous static RAM area. A requester presents an address, write data, byte enables and a read/write flag, and holds `req_valid` until the controller returns a one-cycle `rsp_ready`. The controller drives chip selects, the memory address, output-enable and write-enable. It holds each memory phase for a programmed number of extra cycles, with separate counts for reads and for writes.

The external data path is either 8 bits or 32 bits wide. On an 8-bit area, a word access becomes a series of byte accesses in ascending address order. On a 32-bit area, a partial write can be carried out as read, merge, write. The memory space is split into banks whose size is programmable, and each bank has its own select line. The area can be switched off when an SDRAM controller owns the address range. The switch takes effect only while SDRAM is enabled.

Configuration inputs are expected to stay constant while a request is in progress. The requester removes `req_valid` in the cycle in which it sees `rsp_ready`.

Top module: `sram_ws_ctrl`

## Requirements
- R1: A read phase holds `mem_oe` and a stable `mem_addr` for 1 + `cfg_rd_ws` cycles. A 32-bit read returns `rsp_ready` 1 + `cfg_rd_ws` cycles after the edge that accepts it.
- R2: A write phase holds `mem_we`, `mem_addr` and `mem_wdata` for 1 + `cfg_wr_ws` cycles. This count is independent of the read wait states.
- R3: When `cfg_width[1]` is 0, the area is 8 bits wide. A read then performs four byte reads at word-aligned address + 0, 1, 2, 3 in that order. Each byte arrives on `mem_rdata[7:0]` and is placed in byte i (bits 8i+7..8i) of the response. When `cfg_width[1]` is 1, the area is 32 bits wide.
- R4: An 8-bit write accesses only the bytes whose enable bit is set, in ascending order. Each byte is driven on `mem_wdata[7:0]` for 1 + `cfg_wr_ws` cycles. A write with no enabled byte makes no memory access.
- R5: On a 32-bit area with `cfg_rmw_en` set, a write with `req_be` other than 1111 runs as follows: a full-word read, then replacement of the enabled bytes, then a full-word write. It costs (1 + `cfg_rd_ws`) + (1 + `cfg_wr_ws`) cycles.
- R6: On a 32-bit area with `cfg_rmw_en` clear, any write is a single full-word write of `req_wdata` as presented.
- R7: The bank size is 8 KiB × 2^`cfg_bank_sz`. `mem_cs` bit k is active during an access whose address divided by the bank size equals k. An address beyond the last bank selects nothing. At most one select is ever active.
- R8: With `cfg_sram_dis` and `cfg_sdram_en` both set, a request is answered with `rsp_ready` right after acceptance. The response carries zero data and there is no select, output-enable or write-enable. `cfg_sram_dis` alone has no effect.
- R9: `rsp_ready` is high for exactly one cycle, the cycle after the last wait state of the final sub-access. `rsp_rdata` is valid in that cycle and is zero for writes.
- R10: After reset, `mem_cs`, `mem_oe`, `mem_we` and `rsp_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_ws | input | 2 | Extra cycles per read phase |
| cfg_wr_ws | input | 2 | Extra cycles per write phase |
| cfg_width | input | 2 | Data width: 0x = 8-bit, 1x = 32-bit |
| cfg_rmw_en | input | 1 | Read-modify-write for partial 32-bit writes |
| cfg_bank_sz | input | 4 | Bank size exponent n (8 KiB × 2^n) |
| cfg_sram_dis | input | 1 | Area off request |
| cfg_sdram_en | input | 1 | SDRAM controller active |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_ready | output | 1 | One-cycle completion |
| rsp_rdata | output | 32 | Read data |
| mem_cs | output | NBANK | Bank selects, active high |
| mem_addr | output | AW | Memory byte address |
| mem_oe | output | 1 | Output enable, active high |
| mem_we | output | 1 | Write enable, active high |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench measures the cycles from acceptance to ready and counts the output-enable and write-enable cycles. A counter that is off by one in any phase therefore shows up as a wrong latency or a wrong pulse count. Partial writes are read back after both the merging and the non-merging variant. A design that wrote the whole word when merging was requested, or that merged when it was not, returns the wrong bytes. In 8-bit mode, a write with sparse byte enables shows whether disabled bytes are skipped and whether byte order is kept. The bank tests cover bank indices across two bank sizes and an address past the last bank. The disable tests cover the disable bit with and without SDRAM enabled: a design that ignored the SDRAM condition would block accesses that should go through, or would let blocked accesses alter memory.

// File: rtl/sram_ws_pkg.sv
package sram_ws_pkg;
    localparam int BASE_SHIFT = 13;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_DONE = 2'd3
    } phase_e;
endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode import sram_ws_pkg::*; #(
    parameter int AW    = 26,
    parameter int NBANK = 4
) (
    input  logic [AW-1:0]    addr,
    input  logic [3:0]       bank_sz,
    output logic [NBANK-1:0] sel
);
    logic [AW-1:0] bank_idx;

    always_comb begin
        bank_idx = addr >> (BASE_SHIFT + int'(bank_sz));
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_sel
        assign sel[b] = (bank_idx == AW'(b));
    end
endmodule

// File: rtl/sram_byte_merge.sv
module sram_byte_merge import sram_ws_pkg::*; (
    input  logic [8*WORD_BYTES-1:0] old_word,
    input  logic [8*WORD_BYTES-1:0] new_word,
    input  logic [WORD_BYTES-1:0]   be,
    output logic [8*WORD_BYTES-1:0] merged
);
    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        assign merged[8*i +: 8] = be[i] ? new_word[8*i +: 8] : old_word[8*i +: 8];
    end
endmodule

// File: rtl/sram_ws_ctrl.sv
module sram_ws_ctrl import sram_ws_pkg::*; #(
    parameter int AW    = 26,
    parameter int NBANK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_rd_ws,
    input  logic [1:0]       cfg_wr_ws,
    input  logic [1:0]       cfg_width,
    input  logic             cfg_rmw_en,
    input  logic [3:0]       cfg_bank_sz,
    input  logic             cfg_sram_dis,
    input  logic             cfg_sdram_en,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [31:0]      req_wdata,
    input  logic [3:0]       req_be,
    output logic             rsp_ready,
    output logic [31:0]      rsp_rdata,
    output logic [NBANK-1:0] mem_cs,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_oe,
    output logic             mem_we,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata
);
    localparam int DW = 8 * WORD_BYTES;

    typedef struct packed {
        phase_e          st;
        logic [1:0]      cnt;
        logic [1:0]      idx;
        logic            narrow;
        logic            rmw;
        logic            write;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic [3:0]      be;
        logic [NBANK-1:0] sel;
        logic [DW-1:0]   rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             blocked;
    logic [NBANK-1:0] sel_dec;
    logic [DW-1:0]    merged;
    logic [2:0]       first_en;
    logic [2:0]       after_en;

    function automatic logic [2:0] next_en(input logic [3:0] be, input int from);
        logic [2:0] r;
        r = 3'b000;
        for (int i = 3; i >= 0; i--) begin
            if (i >= from && be[i]) r = {1'b1, 2'(i)};
        end
        return r;
    endfunction

    sram_bank_decode #(.AW(AW), .NBANK(NBANK)) dec_i (
        .addr    (req_addr),
        .bank_sz (cfg_bank_sz),
        .sel     (sel_dec)
    );

    sram_byte_merge merge_i (
        .old_word (mem_rdata),
        .new_word (ctl_q.wdata),
        .be       (ctl_q.be),
        .merged   (merged)
    );

    assign blocked  = cfg_sram_dis & cfg_sdram_en;
    assign first_en = next_en(req_be, 0);
    assign after_en = next_en(ctl_q.be, int'(ctl_q.idx) + 1);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr   = req_addr;
                    ctl_d.wdata  = req_wdata;
                    ctl_d.be     = req_be;
                    ctl_d.write  = req_write;
                    ctl_d.rdata  = '0;
                    ctl_d.sel    = sel_dec;
                    ctl_d.narrow = ~cfg_width[1];
                    ctl_d.rmw    = 1'b0;
                    ctl_d.idx    = 2'd0;
                    if (blocked) begin
                        ctl_d.st = ST_DONE;
                    end else if (!req_write) begin
                        ctl_d.st  = ST_RD;
                        ctl_d.cnt = cfg_rd_ws;
                    end else if (!cfg_width[1]) begin
                        if (first_en[2]) begin
                            ctl_d.st  = ST_WR;
                            ctl_d.idx = first_en[1:0];
                            ctl_d.cnt = cfg_wr_ws;
                        end else begin
                            ctl_d.st = ST_DONE;
                        end
                    end else if (req_be != 4'hF && cfg_rmw_en) begin
                        ctl_d.st  = ST_RD;
                        ctl_d.rmw = 1'b1;
                        ctl_d.cnt = cfg_rd_ws;
                    end else begin
                        ctl_d.st  = ST_WR;
                        ctl_d.cnt = cfg_wr_ws;
                    end
                end
            end
            ST_RD: begin
                if (ctl_q.cnt != 2'd0) begin
                    ctl_d.cnt = ctl_q.cnt - 2'd1;
                end else if (ctl_q.narrow) begin
                    ctl_d.rdata[{ctl_q.idx, 3'b000} +: 8] = mem_rdata[7:0];
                    if (ctl_q.idx == 2'd3) begin
                        ctl_d.st = ST_DONE;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 2'd1;
                        ctl_d.cnt = cfg_rd_ws;
                    end
                end else if (ctl_q.rmw) begin
                    ctl_d.wdata = merged;
                    ctl_d.rmw   = 1'b0;
                    ctl_d.st    = ST_WR;
                    ctl_d.cnt   = cfg_wr_ws;
                end else begin
                    ctl_d.rdata = mem_rdata;
                    ctl_d.st    = ST_DONE;
                end
            end
            ST_WR: begin
                if (ctl_q.cnt != 2'd0) begin
                    ctl_d.cnt = ctl_q.cnt - 2'd1;
                end else if (ctl_q.narrow && after_en[2]) begin
                    ctl_d.idx = after_en[1:0];
                    ctl_d.cnt = cfg_wr_ws;
                end else begin
                    ctl_d.st = ST_DONE;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic in_phase;
    assign in_phase  = (ctl_q.st == ST_RD) || (ctl_q.st == ST_WR);
    assign mem_cs    = in_phase ? ctl_q.sel : '0;
    assign mem_oe    = (ctl_q.st == ST_RD);
    assign mem_we    = (ctl_q.st == ST_WR);
    assign mem_addr  = ctl_q.narrow ? {ctl_q.addr[AW-1:2], ctl_q.idx}
                                    : {ctl_q.addr[AW-1:2], 2'b00};
    assign mem_wdata = ctl_q.narrow ? {24'h0, ctl_q.wdata[{ctl_q.idx, 3'b000} +: 8]}
                                    : ctl_q.wdata;
    assign rsp_ready = (ctl_q.st == ST_DONE);
    assign rsp_rdata = ctl_q.rdata;

    // R9: completion is a single-cycle pulse
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R7: never more than one bank selected
    a_r7_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_cs));

    // R1: a read phase with wait states left keeps enable and address
    a_r1_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe && ctl_q.cnt != 2'd0) |=> (mem_oe && $stable(mem_addr)));

    // R2: a write phase with wait states left keeps enable, address and data
    a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ctl_q.cnt != 2'd0) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    // R5: the read of a merge sequence is followed by the write
    a_r5_rmw_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe && ctl_q.rmw && ctl_q.cnt == 2'd0) |=> mem_we);

    // R8: a blocked request completes at once without touching memory
    a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && req_valid && blocked) |=> (rsp_ready && mem_cs == '0));
endmodule

// File: tb/sram_ws_ctrl_tb.sv
module sram_ws_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 26;
    localparam int NBANK = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_rd_ws = 2'd0, cfg_wr_ws = 2'd0, cfg_width = 2'b10;
    logic cfg_rmw_en = 1'b1, cfg_sram_dis = 1'b0, cfg_sdram_en = 1'b0;
    logic [3:0] cfg_bank_sz = 4'd0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0] req_be = '0;
    logic rsp_ready, mem_oe, mem_we;
    logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [NBANK-1:0] mem_cs;
    logic [AW-1:0] mem_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ws_ctrl #(.AW(AW), .NBANK(NBANK)) dut_i (
        .clk, .rst_n, .cfg_rd_ws, .cfg_wr_ws, .cfg_width, .cfg_rmw_en,
        .cfg_bank_sz, .cfg_sram_dis, .cfg_sdram_en, .req_valid, .req_write,
        .req_addr, .req_wdata, .req_be, .rsp_ready, .rsp_rdata, .mem_cs,
        .mem_addr, .mem_oe, .mem_we, .mem_wdata, .mem_rdata
    );

    // behavioural memory, low 8 address bits
    logic [7:0] mem [256];
    logic [7:0] shadow [256];
    logic [7:0] ma;
    assign ma = mem_addr[7:0];
    assign mem_rdata = cfg_width[1]
        ? {mem[{ma[7:2], 2'd3}], mem[{ma[7:2], 2'd2}], mem[{ma[7:2], 2'd1}], mem[{ma[7:2], 2'd0}]}
        : {24'h0, mem[ma]};

    always @(posedge clk) begin
        if (mem_we && |mem_cs) begin
            if (cfg_width[1]) begin
                for (int i = 0; i < 4; i++) mem[{ma[7:2], 2'(i)}] <= mem_wdata[8*i +: 8];
            end else begin
                mem[ma] <= mem_wdata[7:0];
            end
        end
    end

    typedef struct {
        logic [31:0] rd;
        int lat;
        int oe;
        int we;
        logic [3:0] cs;
        bit chk_rd;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [3:0] exp_cs(input logic [AW-1:0] a);
        logic [AW-1:0] k;
        k = a >> (13 + int'(cfg_bank_sz));
        return (k < NBANK) ? 4'(1 << k) : 4'h0;
    endfunction

    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input bit chk, input string tag);
        exp_t e;
        bit blk, narrow;
        int rd1, wr1, pop;
        logic [7:0] base;
        blk = cfg_sram_dis && cfg_sdram_en;
        narrow = !cfg_width[1];
        rd1 = 1 + int'(cfg_rd_ws);
        wr1 = 1 + int'(cfg_wr_ws);
        pop = $countones(be);
        base = {a[7:2], 2'b00};
        e.tag = tag; e.chk_rd = chk; e.rd = 32'h0; e.oe = 0; e.we = 0;
        e.cs = blk ? 4'h0 : exp_cs(a);
        if (blk) begin
            e.lat = 0;
        end else if (!wr) begin
            e.oe = narrow ? 4 * rd1 : rd1;
            e.rd = {shadow[base+3], shadow[base+2], shadow[base+1], shadow[base]};
        end else if (narrow) begin
            e.we = pop * wr1;
            if (pop == 0) e.cs = 4'h0;
        end else if (be != 4'hF && cfg_rmw_en) begin
            e.oe = rd1; e.we = wr1;
        end else begin
            e.we = wr1;
        end
        if (!blk) e.lat = e.oe + e.we;
        if (wr && !blk && e.cs != 0) begin
            for (int i = 0; i < 4; i++) begin
                if (be[i] || (!narrow && !cfg_rmw_en)) shadow[base + 8'(i)] = wd[8*i +: 8];
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        do @(negedge clk); while (!rsp_ready);
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    int lat_c = 0, oe_c = 0, we_c = 0;
    logic [3:0] cs_or = 4'h0;
    bit prev_ready = 0;
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (prev_ready) check(!rsp_ready, "R9", "ready width", rsp_ready, 0);
            if (rsp_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected ready", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(lat_c == e.lat, e.tag, "latency", lat_c, e.lat);
                    check(oe_c == e.oe, e.tag, "oe cycles", oe_c, e.oe);
                    check(we_c == e.we, e.tag, "we cycles", we_c, e.we);
                    check(cs_or == e.cs, e.tag, "chip select", cs_or, e.cs);
                    if (e.chk_rd) check(rsp_rdata == e.rd, e.tag, "rdata", rsp_rdata, e.rd);
                end
                lat_c = 0; oe_c = 0; we_c = 0; cs_or = 4'h0;
            end else if (req_valid) begin
                lat_c++;
                if (mem_oe) oe_c++;
                if (mem_we) we_c++;
                cs_or = cs_or | mem_cs;
            end
            prev_ready = rsp_ready;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h0; shadow[i] = 8'h0; end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(mem_cs == 0 && !mem_oe && !mem_we && !rsp_ready, "R10", "reset outputs",
              {mem_cs, mem_oe, mem_we, rsp_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // 32-bit area
        do_req(1, 26'h10, 32'h11223344, 4'hF, 1, "R2");
        cfg_rd_ws = 2'd2;
        do_req(0, 26'h10, 32'h0, 4'hF, 1, "R1");
        cfg_wr_ws = 2'd3; cfg_rd_ws = 2'd1;
        do_req(1, 26'h14, 32'hCAFEF00D, 4'hF, 1, "R2");
        do_req(0, 26'h14, 32'h0, 4'hF, 1, "R1");
        // R5: merge sequence
        do_req(1, 26'h10, 32'hAABBCCDD, 4'b0100, 1, "R5");
        do_req(0, 26'h10, 32'h0, 4'hF, 1, "R5");
        // R6: no merge
        cfg_rmw_en = 1'b0; cfg_wr_ws = 2'd1;
        do_req(1, 26'h14, 32'h55667788, 4'b0001, 1, "R6");
        do_req(0, 26'h14, 32'h0, 4'hF, 1, "R6");
        cfg_rmw_en = 1'b1;
        // R3 / R4: 8-bit area
        cfg_width = 2'b00; cfg_rd_ws = 2'd1; cfg_wr_ws = 2'd2;
        do_req(0, 26'h10, 32'h0, 4'hF, 1, "R3");
        do_req(1, 26'h18, 32'hDEADBEEF, 4'b1010, 1, "R4");
        do_req(0, 26'h18, 32'h0, 4'hF, 1, "R4");
        cfg_width = 2'b01; cfg_wr_ws = 2'd0;
        do_req(1, 26'h1C, 32'h0A0B0C0D, 4'b0001, 1, "R4");
        do_req(1, 26'h1C, 32'h0, 4'b0000, 1, "R4");
        cfg_rd_ws = 2'd0;
        do_req(0, 26'h1C, 32'h0, 4'hF, 1, "R3");
        // R7: bank decode
        cfg_width = 2'b11;
        do_req(0, 26'h2010, 32'h0, 4'hF, 1, "R7");
        do_req(0, 26'h6010, 32'h0, 4'hF, 1, "R7");
        cfg_bank_sz = 4'd1;
        do_req(0, 26'h6010, 32'h0, 4'hF, 1, "R7");
        cfg_bank_sz = 4'd0;
        do_req(1, 26'h8010, 32'h99999999, 4'hF, 1, "R7");
        do_req(0, 26'h8010, 32'h0, 4'hF, 0, "R7");
        do_req(0, 26'h10, 32'h0, 4'hF, 1, "R7");
        // R8: disable
        cfg_sram_dis = 1'b1;
        do_req(0, 26'h10, 32'h0, 4'hF, 1, "R8");
        cfg_sdram_en = 1'b1;
        do_req(0, 26'h10, 32'h0, 4'hF, 1, "R8");
        do_req(1, 26'h10, 32'h77777777, 4'hF, 1, "R8");
        cfg_sram_dis = 1'b0;
        do_req(0, 26'h10, 32'h0, 4'hF, 1, "R8");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending responses", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule